// File: doc/BRIEF.md
# History-Majority Branch Predictor

This block guesses the direction of a conditional or unconditional control transfer before it resolves. It holds a small direct-mapped table of entries, one per index taken from the branch address. Each entry remembers the three most recent resolved directions of the branches that map to it, plus a saturating count of how many directions it has seen since reset. Once an entry has seen at least three outcomes, the guess is the majority of those three. Until then, the guess comes from a fixed rule that depends on the kind of branch presented with the lookup.

A fetch stage drives the lookup port with a branch address and a 2-bit kind code and reads the guess back in the same cycle, with no register in the path. An execute stage reports each resolved direction on the update port. The update is written at the next rising clock edge, so a lookup of the same entry in the same cycle still sees the state from before the update.

Top module: `hmaj_branch_predictor`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties every entry, so every lookup afterwards uses the kind-based rule of R2 to R4 until that entry has again received three updates.
- R2: While the selected entry has received fewer than three updates, a lookup with kind code 2'b00 (conditional) predicts not taken (`lk_taken` = 0).
- R3: While the selected entry has received fewer than three updates, a lookup with kind code 2'b01 (loop) predicts taken.
- R4: While the selected entry has received fewer than three updates, a lookup with kind code 2'b10 (unconditional) or 2'b11 (call/return) predicts taken.
- R5: Once the selected entry has received three or more updates, the prediction is taken exactly when at least two of its last three recorded outcomes were taken, whatever the kind code.
- R6: Each update appends its outcome as the newest of the entry's three remembered outcomes and drops the oldest one.
- R7: The per-entry update count stops at three, so further updates never return the entry to the kind-based rule; one or two updates alone do not end the kind-based rule.
- R8: The entry is selected by address bits [5:2]; addresses that differ only in other bits share an entry, and an update to one entry leaves every other entry unchanged.
- R9: A lookup made in the same cycle as an update to the same entry returns the prediction from before that update; the update is visible from the next cycle.
- R10: When `up_en` is low, `up_pc` and `up_taken` have no effect on any entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | PC_W (32) | Address of the branch being looked up |
| lk_kind | input | 2 | Branch kind: 00 conditional, 01 loop, 10 unconditional, 11 call/return |
| lk_taken | output | 1 | Prediction for the lookup, combinational: 1 taken, 0 not taken |
| up_en | input | 1 | Update strobe: record a resolved outcome at the next edge |
| up_pc | input | PC_W (32) | Address of the resolved branch |
| up_taken | input | 1 | Resolved direction: 1 taken, 0 not taken |

## Verification
The prediction is combinational from the lookup inputs and the stored table, so it is due in the same cycle as the lookup; the bench changes the lookup inputs away from the clock edge and samples after a short settling delay before the next rising edge. An update takes effect at exactly the first rising edge with `up_en` high, so every check of its effect is made after that edge and before the following one, and the same-cycle case is sampled before the edge to see the old value and again after it to see the new one. Each directed task builds an entry's history one update per cycle and compares against a majority computed in the bench from the outcome list it applied.

// File: rtl/hmaj_bp_pkg.sv
package hmaj_bp_pkg;

  localparam int HIST_D   = 3;
  localparam int CNT_W    = 2;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(HIST_D);

  typedef enum logic [1:0] {
    BK_COND    = 2'b00,
    BK_LOOP    = 2'b01,
    BK_JUMP    = 2'b10,
    BK_CALLRET = 2'b11
  } br_kind_e;

  // Majority of the three stored outcomes.
  function automatic logic vote3(input logic [HIST_D-1:0] h);
    return (h[0] & h[1]) | (h[0] & h[2]) | (h[1] & h[2]);
  endfunction

  // Kind-based guess used while an entry is still warming up.
  // Anything not recognised falls back to never-taken.
  function automatic logic static_guess(input logic [1:0] kind);
    logic g;
    case (kind)
      BK_COND:    g = 1'b0;
      BK_LOOP:    g = 1'b1;
      BK_JUMP:    g = 1'b1;
      BK_CALLRET: g = 1'b1;
      default:    g = 1'b0;
    endcase
    return g;
  endfunction

  // Next value of the saturating update count.
  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c);
    return (c == CNT_FULL) ? c : c + CNT_W'(1);
  endfunction

endpackage

// File: rtl/hmaj_bp_entry.sv
module hmaj_bp_entry
  import hmaj_bp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_taken,
  output logic [HIST_D-1:0] hist_o,
  output logic [CNT_W-1:0]  cnt_o
);

  logic [HIST_D-1:0] hist_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      cnt_q  <= '0;
    end else if (wr_en) begin
      hist_q <= {hist_q[HIST_D-2:0], wr_taken};
      cnt_q  <= cnt_next(cnt_q);
    end
  end

  assign hist_o = hist_q;
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/hmaj_bp_lookup.sv
module hmaj_bp_lookup
  import hmaj_bp_pkg::*;
#(
  parameter int IDX_W   = 4,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic [ENTRIES*HIST_D-1:0] hist_flat,
  input  logic [ENTRIES*CNT_W-1:0]  cnt_flat,
  input  logic [IDX_W-1:0]          idx,
  input  logic [1:0]                kind,
  output logic                      taken
);

  logic [HIST_D-1:0] sel_hist;
  logic [CNT_W-1:0]  sel_cnt;
  logic              warm;

  always_comb begin
    sel_hist = hist_flat[idx*HIST_D +: HIST_D];
    sel_cnt  = cnt_flat[idx*CNT_W +: CNT_W];
    warm     = (sel_cnt == CNT_FULL);
    taken    = warm ? vote3(sel_hist) : static_guess(kind);
  end

endmodule

// File: rtl/hmaj_branch_predictor.sv
module hmaj_branch_predictor
  import hmaj_bp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 4,
  parameter int IDX_LSB = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  input  logic [1:0]      lk_kind,
  output logic            lk_taken,
  input  logic            up_en,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

  // Named internal wires, also observed by the checker.
  logic [IDX_W-1:0]          lk_idx;
  logic [IDX_W-1:0]          up_idx;
  logic [ENTRIES*HIST_D-1:0] hist_flat;
  logic [ENTRIES*CNT_W-1:0]  cnt_flat;

  assign lk_idx = lk_pc[IDX_MSB:IDX_LSB];
  assign up_idx = up_pc[IDX_MSB:IDX_LSB];

  // Address bits outside the index field play no part.
  logic pc_unused_bits;
  assign pc_unused_bits = ^{lk_pc[PC_W-1:IDX_MSB+1], lk_pc[IDX_LSB-1:0],
                            up_pc[PC_W-1:IDX_MSB+1], up_pc[IDX_LSB-1:0]};

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic hit;
    assign hit = up_en && (up_idx == IDX_W'(e));
    hmaj_bp_entry u_ent (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (hit),
      .wr_taken (up_taken),
      .hist_o   (hist_flat[e*HIST_D +: HIST_D]),
      .cnt_o    (cnt_flat[e*CNT_W +: CNT_W])
    );
  end

  hmaj_bp_lookup #(.IDX_W(IDX_W)) u_lookup (
    .hist_flat (hist_flat),
    .cnt_flat  (cnt_flat),
    .idx       (lk_idx),
    .kind      (lk_kind),
    .taken     (lk_taken)
  );

endmodule

// File: rtl/hmaj_bp_checker.sv
module hmaj_bp_checker
  import hmaj_bp_pkg::*;
#(
  parameter int IDX_W   = 4,
  localparam int ENTRIES = 1 << IDX_W
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      up_en,
  input logic [IDX_W-1:0]          up_idx,
  input logic                      up_taken,
  input logic [IDX_W-1:0]          lk_idx,
  input logic [1:0]                lk_kind,
  input logic                      lk_taken,
  input logic [ENTRIES*HIST_D-1:0] hist_flat,
  input logic [ENTRIES*CNT_W-1:0]  cnt_flat
);

  // R1: reset empties the whole table.
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (cnt_flat == '0) && (hist_flat == '0));

  // R10: nothing moves without the update strobe.
  assert_idle_no_change_R10: assert property (@(posedge clk) disable iff (rst)
    !up_en |=> $stable(hist_flat) && $stable(cnt_flat));

  // R5: a full entry predicts by majority, counted here with $countones.
  assert_majority_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt_flat[lk_idx*CNT_W +: CNT_W] == CNT_FULL) |->
      (lk_taken == ($countones(hist_flat[lk_idx*HIST_D +: HIST_D]) >= 2)));

  // R2: a warming conditional lookup is never taken.
  assert_cond_fallback_R2: assert property (@(posedge clk) disable iff (rst)
    ((cnt_flat[lk_idx*CNT_W +: CNT_W] != CNT_FULL) && (lk_kind == 2'b00)) |-> !lk_taken);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_chk
    // R6: the written entry takes the new outcome at its newest position.
    assert_shift_in_R6: assert property (@(posedge clk) disable iff (rst)
      (up_en && up_idx == IDX_W'(e)) |=>
        hist_flat[e*HIST_D +: HIST_D] ==
          {$past(hist_flat[e*HIST_D +: HIST_D-1]), $past(up_taken)});
    // R7: a full count stays full.
    assert_count_saturates_R7: assert property (@(posedge clk) disable iff (rst)
      (cnt_flat[e*CNT_W +: CNT_W] == CNT_FULL) |=> (cnt_flat[e*CNT_W +: CNT_W] == CNT_FULL));
    // R8: other entries keep their state during an update.
    assert_other_entries_kept_R8: assert property (@(posedge clk) disable iff (rst)
      (up_en && up_idx != IDX_W'(e)) |=>
        $stable(hist_flat[e*HIST_D +: HIST_D]) && $stable(cnt_flat[e*CNT_W +: CNT_W]));
  end

endmodule

bind hmaj_branch_predictor hmaj_bp_checker #(.IDX_W(IDX_W)) u_hmaj_bp_checker (
  .clk       (clk),
  .rst       (rst),
  .up_en     (up_en),
  .up_idx    (up_idx),
  .up_taken  (up_taken),
  .lk_idx    (lk_idx),
  .lk_kind   (lk_kind),
  .lk_taken  (lk_taken),
  .hist_flat (hist_flat),
  .cnt_flat  (cnt_flat)
);

// File: tb/hmaj_branch_predictor_tb.sv
`timescale 1ns/1ps
module hmaj_branch_predictor_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_pc = '0;
  logic [1:0]  lk_kind = 2'b00;
  logic        lk_taken;
  logic        up_en = 1'b0;
  logic [31:0] up_pc = '0;
  logic        up_taken = 1'b0;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  hmaj_branch_predictor u_dut (
    .clk      (clk),
    .rst      (rst),
    .lk_pc    (lk_pc),
    .lk_kind  (lk_kind),
    .lk_taken (lk_taken),
    .up_en    (up_en),
    .up_pc    (up_pc),
    .up_taken (up_taken)
  );

  // Bench-side majority of three outcomes.
  function automatic logic maj(input logic a, input logic b, input logic c);
    int s;
    s = int'(a) + int'(b) + int'(c);
    return s >= 2;
  endfunction

  task automatic check(input logic got, input logic exp, input string req, input string what);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  // Lookup away from the edge; result is combinational.
  task automatic look(input logic [31:0] pc, input logic [1:0] kind, input logic exp,
                      input string req, input string what);
    lk_pc   = pc;
    lk_kind = kind;
    #1;
    check(lk_taken, exp, req, what);
  endtask

  // One update, written at the next rising edge.
  task automatic upd(input logic [31:0] pc, input logic t);
    @(negedge clk);
    up_en = 1'b1; up_pc = pc; up_taken = t;
    @(negedge clk);
    up_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_fallback();
    do_reset();
    look(32'h0000_0010, 2'b00, 1'b0, "R1", "after reset cond");
    look(32'h0000_0010, 2'b00, 1'b0, "R2", "cond fallback");
    look(32'h0000_0014, 2'b01, 1'b1, "R3", "loop fallback");
    look(32'h0000_0018, 2'b10, 1'b1, "R4", "unconditional fallback");
    look(32'h0000_001C, 2'b11, 1'b1, "R4", "call/return fallback");
  endtask

  task automatic t_warmup_and_shift();
    // Entry 1 (pc 0x4): T, T keeps the kind rule (R7), then N fills it.
    upd(32'h0000_0004, 1'b1);
    upd(32'h0000_0004, 1'b1);
    @(negedge clk);
    look(32'h0000_0004, 2'b00, 1'b0, "R7", "two updates still cond fallback");
    look(32'h0000_0004, 2'b01, 1'b1, "R7", "two updates still loop fallback");
    upd(32'h0000_0004, 1'b0);
    @(negedge clk);
    look(32'h0000_0004, 2'b00, maj(1, 1, 0), "R5", "T,T,N majority overrides cond");
    upd(32'h0000_0004, 1'b0);
    @(negedge clk);
    look(32'h0000_0004, 2'b01, maj(1, 0, 0), "R6", "oldest T dropped, loop kind");
    upd(32'h0000_0004, 1'b1);
    @(negedge clk);
    look(32'h0000_0004, 2'b11, maj(0, 0, 1), "R6", "N,N,T");
    upd(32'h0000_0004, 1'b1);
    @(negedge clk);
    look(32'h0000_0004, 2'b00, maj(0, 1, 1), "R5", "N,T,T");
    for (int k = 0; k < 4; k++) upd(32'h0000_0004, 1'b0);
    @(negedge clk);
    look(32'h0000_0004, 2'b10, 1'b0, "R7", "count saturated, majority kept");
  endtask

  task automatic t_index_alias();
    // Entry 1 now holds N,N,N. Bit 6 and bit 1 lie outside the index.
    look(32'h0000_0046, 2'b01, 1'b0, "R8", "aliased address shares entry");
    look(32'h0000_0008, 2'b01, 1'b1, "R8", "neighbour entry untouched");
    look(32'h0000_0008, 2'b00, 1'b0, "R8", "neighbour entry cond fallback");
  endtask

  task automatic t_same_cycle();
    for (int k = 0; k < 3; k++) upd(32'h0000_000C, 1'b1);
    upd(32'h0000_000C, 1'b0);
    @(negedge clk);
    look(32'h0000_000C, 2'b00, maj(1, 1, 0), "R9", "before collision T,T,N");
    up_en = 1'b1; up_pc = 32'h0000_000C; up_taken = 1'b0;
    look(32'h0000_000C, 2'b00, 1'b1, "R9", "same-cycle lookup sees old state");
    @(negedge clk);
    up_en = 1'b0;
    look(32'h0000_000C, 2'b00, maj(1, 0, 0), "R9", "update visible next cycle");
  endtask

  task automatic t_idle_update();
    // Entry 3 holds T,N,N. Three applied T's would make it taken.
    @(negedge clk);
    up_en = 1'b0; up_pc = 32'h0000_000C; up_taken = 1'b1;
    repeat (3) @(negedge clk);
    look(32'h0000_000C, 2'b01, 1'b0, "R10", "strobe low leaves entry unchanged");
  endtask

  task automatic t_reset_again();
    do_reset();
    look(32'h0000_000C, 2'b01, 1'b1, "R1", "reset restores loop fallback");
    look(32'h0000_0004, 2'b00, 1'b0, "R1", "reset restores cond fallback");
    look(32'h0000_0004, 2'b10, 1'b1, "R1", "reset restores jump fallback");
  endtask

  initial begin
    #1000000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    t_reset_fallback();
    t_warmup_and_shift();
    t_index_alias();
    t_same_cycle();
    t_idle_update();
    t_reset_again();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule